// File: doc/BRIEF.md
# Sequential Signed-Magnitude Restoring Divider

This block divides a double-width unsigned dividend magnitude by a single-width divisor magnitude. Each operand carries its own sign bit. It works one quotient bit per clock using shift-and-subtract. A pulse on `start` captures the operands. The block first checks whether the quotient would fit in N bits. If it fits, the block runs N iterations. In each iteration it shifts the remainder/quotient pair left, tries to subtract the divisor, and keeps the difference only when the subtraction does not borrow.

When the work ends, `done` goes high. `done`, the quotient, the remainder, both result signs and the overflow flag all hold until the next accepted `start`. The quotient sign is the exclusive-OR of the two operand signs. The remainder takes the dividend's sign. A divisor of zero always reports overflow.

Top module: `sm_divider`

## Requirements
- R1: When the upper N bits of the dividend are below the divisor, the block finishes with `ovf`=0, `quo` equal to floor(dividend/divisor) and `rem` equal to dividend mod divisor, and `rem` is below the divisor.
- R2: `quo_sign` equals `dvd_sign` XOR `dvs_sign`, and `rem_sign` equals `dvd_sign`. Both are taken at the accepted `start`.
- R3: When the upper N bits of the dividend are greater than or equal to the divisor, the block finishes with `ovf`=1. In that case `rem` holds the upper N dividend bits and `quo` holds the lower N dividend bits.
- R4: A divisor of zero always ends with `ovf`=1, whatever the dividend.
- R5: `done` rises N+2 clock edges after the edge that samples `start` (that edge included) when there is no overflow, and 2 edges after it when there is overflow.
- R6: `busy` is 1 from the edge after an accepted `start` until `done` rises. `busy` and `done` are never 1 together.
- R7: A `start` pulse while `busy` is 1 is ignored. The running division completes with its original operands.
- R8: After `done` rises, `done`, `quo`, `rem`, `ovf` and both signs hold their values until the next `start`. An accepted `start` drops `done` on the following edge.
- R9: After reset, `done`, `busy`, `ovf`, `quo` and `rem` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division (accepted when not busy) |
| dvd_sign | input | 1 | Dividend sign |
| dvd_mag | input | 2N | Dividend magnitude |
| dvs_sign | input | 1 | Divisor sign |
| dvs_mag | input | N | Divisor magnitude |
| busy | output | 1 | Division in progress |
| done | output | 1 | Results valid |
| ovf | output | 1 | Divide overflow (including zero divisor) |
| quo | output | N | Quotient magnitude |
| rem | output | N | Remainder magnitude |
| quo_sign | output | 1 | Quotient sign |
| rem_sign | output | 1 | Remainder sign |

## Verification
The assertions assume that `start` is only a meaningful request when the block is idle or done. The hold and done-clear properties therefore condition on `busy` being low. The bench drives every input half a period away from the rising edge and holds operand values steady around each `start` pulse. It issues one overlapping `start` during a running division on purpose, and compares the final result at the ports against the first operand set. The remainder-below-divisor property holds only for non-overflow results, so it is gated by `ovf`.

// File: rtl/sm_div_pkg.sv
package sm_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_ITER  = 2'd2,
    ST_DONE  = 2'd3
  } div_state_t;
endpackage

// File: rtl/sm_div_sub.sv
module sm_div_sub #(
  parameter int W = 8
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtr,
  output logic [W-1:0] diff,
  output logic         no_borrow
);
  // minuend + ~subtr + 1 ; carry out set when minuend >= subtr
  assign {no_borrow, diff} = {1'b0, minuend} + {1'b0, ~subtr} + {{W{1'b0}}, 1'b1};
endmodule

// File: rtl/sm_div_ctrl.sv
module sm_div_ctrl
  import sm_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ovf_hit,
  output div_state_t state,
  output logic       last_step
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] STEPS_M1 = CW'(N - 1);

  div_state_t      state_nxt;
  logic [CW-1:0]   cnt_q, cnt_nxt;
  logic            cnt_en;

  assign last_step = (cnt_q == '0);

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt_q;
    cnt_en    = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: if (start) state_nxt = ST_CHECK;
      ST_CHECK: begin
        cnt_en  = 1'b1;
        cnt_nxt = STEPS_M1;
        state_nxt = ovf_hit ? ST_DONE : ST_ITER;
      end
      ST_ITER: begin
        cnt_en  = 1'b1;
        cnt_nxt = cnt_q - 1'b1;
        if (last_step) state_nxt = ST_DONE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      state <= state_nxt;
      if (cnt_en) cnt_q <= cnt_nxt;
    end
  end

  // R5
  iter_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ITER && last_step) |=> (state == ST_DONE));

  // R3
  check_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK && ovf_hit) |=> (state == ST_DONE));
endmodule

// File: rtl/sm_divider.sv
module sm_divider
  import sm_div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           dvd_sign,
  input  logic [2*N-1:0] dvd_mag,
  input  logic           dvs_sign,
  input  logic [N-1:0]   dvs_mag,
  output logic           busy,
  output logic           done,
  output logic           ovf,
  output logic [N-1:0]   quo,
  output logic [N-1:0]   rem,
  output logic           quo_sign,
  output logic           rem_sign
);
  div_state_t  state;
  logic        last_step;
  logic [N-1:0] a_q, a_nxt, q_q, q_nxt, b_q;
  logic        qs_q, rs_q, ovf_q, ovf_nxt;
  logic        load, step;
  logic        e_bit;
  logic [N-1:0] a_shift, q_shift, sub_in, diff;
  logic        no_borrow;

  sm_div_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ovf_hit   (no_borrow),
    .state     (state),
    .last_step (last_step)
  );

  assign e_bit   = a_q[N-1];
  assign a_shift = {a_q[N-2:0], q_q[N-1]};
  assign q_shift = {q_q[N-2:0], 1'b0};
  assign sub_in  = (state == ST_CHECK) ? a_q : a_shift;

  sm_div_sub #(.W(N)) u_sub (
    .minuend   (sub_in),
    .subtr     (b_q),
    .diff      (diff),
    .no_borrow (no_borrow)
  );

  assign load = start && (state == ST_IDLE || state == ST_DONE);
  assign step = (state == ST_ITER);

  always_comb begin
    a_nxt   = a_q;
    q_nxt   = q_q;
    ovf_nxt = ovf_q;
    if (load) begin
      a_nxt   = dvd_mag[2*N-1:N];
      q_nxt   = dvd_mag[N-1:0];
      ovf_nxt = 1'b0;
    end else if (state == ST_CHECK) begin
      ovf_nxt = no_borrow;
    end else if (step) begin
      if (e_bit || no_borrow) begin
        a_nxt = diff;
        q_nxt = q_shift | {{(N-1){1'b0}}, 1'b1};
      end else begin
        a_nxt = a_shift;
        q_nxt = q_shift;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      q_q   <= '0;
      b_q   <= '0;
      qs_q  <= 1'b0;
      rs_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (load || step) begin
        a_q <= a_nxt;
        q_q <= q_nxt;
      end
      if (load) begin
        b_q  <= dvs_mag;
        qs_q <= dvd_sign ^ dvs_sign;
        rs_q <= dvd_sign;
      end
      if (load || state == ST_CHECK) ovf_q <= ovf_nxt;
    end
  end

  assign busy     = (state == ST_CHECK) || (state == ST_ITER);
  assign done     = (state == ST_DONE);
  assign ovf      = ovf_q;
  assign quo      = q_q;
  assign rem      = a_q;
  assign quo_sign = qs_q;
  assign rem_sign = rs_q;

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(quo) && $stable(rem) && $stable(ovf)));

  // R8
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !done);

  // R1
  rem_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf) |-> (rem < b_q));

  // R3
  ovf_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (done || (state == ST_IDLE)));
endmodule

// File: tb/sm_divider_tb.sv
module sm_divider_tb;
  localparam int N = 8;
  localparam int NV = 10;
  // {dvd_sign, dvs_sign, dvd_mag[15:0], dvs_mag[7:0]}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h01C0, 8'h11},
    {1'b1, 1'b0, 16'h7FFF, 8'h80},
    {1'b0, 1'b1, 16'h1234, 8'h56},
    {1'b1, 1'b1, 16'h0000, 8'h05},
    {1'b0, 1'b0, 16'h00FF, 8'h01},
    {1'b1, 1'b0, 16'hFE01, 8'hFF},
    {1'b0, 1'b1, 16'hABCD, 8'hF0},
    {1'b1, 1'b1, 16'h0500, 8'h05},
    {1'b0, 1'b0, 16'h0010, 8'h00},
    {1'b1, 1'b0, 16'hFFFF, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic dvd_sign = 1'b0, dvs_sign = 1'b0;
  logic [2*N-1:0] dvd_mag = '0;
  logic [N-1:0] dvs_mag = '0;
  logic busy, done, ovf, quo_sign, rem_sign;
  logic [N-1:0] quo, rem;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sm_divider #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dvd_sign(dvd_sign), .dvd_mag(dvd_mag),
    .dvs_sign(dvs_sign), .dvs_mag(dvs_mag),
    .busy(busy), .done(done), .ovf(ovf),
    .quo(quo), .rem(rem), .quo_sign(quo_sign), .rem_sign(rem_sign)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one operation; returns number of negedges until done seen.
  task automatic run(input logic [25:0] v, output int lat);
    @(negedge clk);
    dvd_sign = v[25]; dvs_sign = v[24]; dvd_mag = v[23:8]; dvs_mag = v[7:0];
    start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 100);
  endtask

  task automatic verify(input logic [25:0] v, input int lat);
    int hi, lo, dvd, dvs, eq, er, el;
    logic eo;
    dvd = int'(v[23:8]); dvs = int'(v[7:0]);
    hi = dvd / 256; lo = dvd % 256;
    eo = (hi >= dvs);
    if (eo) begin eq = lo; er = hi; el = 2; end
    else begin eq = dvd / dvs; er = dvd % dvs; el = N + 2; end
    if (dvs == 0) chk(ovf == 1'b1, "R4", "zero divisor ovf", int'(ovf), 1);
    else chk(ovf == eo, eo ? "R3" : "R1", "ovf", int'(ovf), int'(eo));
    chk(int'(quo) == eq, eo ? "R3" : "R1", "quo", int'(quo), eq);
    chk(int'(rem) == er, eo ? "R3" : "R1", "rem", int'(rem), er);
    chk(quo_sign == (v[25] ^ v[24]), "R2", "quo_sign", int'(quo_sign), int'(v[25] ^ v[24]));
    chk(rem_sign == v[25], "R2", "rem_sign", int'(rem_sign), int'(v[25]));
    chk(lat == el, "R5", "latency", lat, el);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int lat;
    logic [N-1:0] sq, sr;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!done && !busy && !ovf, "R9", "flags after reset", int'({done, busy, ovf}), 0);
    chk(quo == '0 && rem == '0, "R9", "data after reset", int'({quo, rem}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i], lat);
      verify(VEC[i], lat);
    end

    // R6 busy during operation, R7 start while busy ignored
    @(negedge clk);
    dvd_sign = 1'b0; dvs_sign = 1'b0; dvd_mag = 16'h01C0; dvs_mag = 8'h11;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R6", "busy after start", int'({busy, done}), 2);
    @(negedge clk);
    @(negedge clk);
    dvd_mag = 16'h0300; dvs_mag = 8'h07; dvd_sign = 1'b1; dvs_sign = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(int'(quo) == 26 && int'(rem) == 6, "R7", "result of first op",
        int'({quo, rem}), (26 << 8) | 6);
    chk(!ovf && !quo_sign && !rem_sign, "R7", "flags of first op",
        int'({ovf, quo_sign, rem_sign}), 0);

    // R8 hold after done
    sq = quo; sr = rem;
    repeat (6) @(negedge clk);
    chk(done && quo == sq && rem == sr, "R8", "hold after done",
        int'({done, quo, rem}), int'({1'b1, sq, sr}));
    // R8 start clears done
    dvd_mag = 16'h0064; dvs_mag = 8'h07;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R8", "done cleared by start", int'(done), 0);
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(int'(quo) == 14 && int'(rem) == 2, "R1", "100/7", int'({quo, rem}), (14 << 8) | 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule